// File: doc/BRIEF.md
# Banked Stack Pointer Register File

This block holds the sixteen architectural 32-bit registers of a small load/store core. Index 13 is not one register but two: a main stack pointer and a process stack pointer, only one of which answers to index 13 at a time. A registered selection bit picks the active pointer. It starts on the main pointer after reset and is changed through a load strobe. A separate special-register port names either pointer explicitly, so software can read or set the pointer that is not currently visible.

Stack traffic does not go through the write port. A push strobe lowers the active pointer by one word and presents the lowered value as the store address in the same cycle, which gives a full-descending stack. A pop strobe presents the current value as the load address and raises the pointer by one word. Both pointers always hold word-aligned values. Index 15 is not stored here. A read of it returns the current instruction address advanced by the pipeline offset, with bit 0 cleared. A write to it becomes a branch request when bit 0 of the target is set, and a fault flag when bit 0 is clear.

Top module: `bsp_regfile`

## Requirements
- R1: Indices 0 to 12 and 14 store the full 32-bit value written. A read and a write of the same index in one cycle return the old value; the new value is visible from the next cycle.
- R2: Bit 0 of index 14 is stored and read back like any other bit.
- R3: Bits 1 and 0 of both stack pointers always read as zero, whatever value is written through the write port or the special port.
- R4: Index 13 reads and writes the active pointer only. The selection resets to main (sel value 0). A load with value 1 selects the process pointer from the next cycle.
- R5: A push puts the active pointer minus 4 on the stack address output in the same cycle and stores that value into the active pointer.
- R6: A pop puts the active pointer on the stack address output and stores the pointer plus 4.
- R7: The special port reads or writes the pointer it names (0 main, 1 process) and leaves the selection unchanged. A special write and a push or pop on the same pointer in one cycle leave the special value in that pointer.
- R8: A read of index 15 returns the instruction address plus 4 with bit 0 forced to zero.
- R9: A write to index 15 with bit 0 set raises the branch request with the written target. With bit 0 clear it raises the fault flag and no branch request. The two outputs are never high together.
- R10: When push and pop arrive in the same cycle, only the push acts.
- R11: The two read ports select and return independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_ld | input | 1 | Load strobe for the active-pointer selection |
| sel_val | input | 1 | New selection (0 main, 1 process) |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port index |
| wr_data | input | 32 | Write port data |
| pc_cur | input | 32 | Address of the executing instruction |
| push | input | 1 | Push strobe on the active pointer |
| pop | input | 1 | Pop strobe on the active pointer |
| stk_addr | output | 32 | Memory address for the push or pop |
| spc_sel | input | 1 | Pointer named by the special port (0 main, 1 process) |
| spc_wr | input | 1 | Special port write strobe |
| spc_wdata | input | 32 | Special port write data |
| spc_rdata | output | 32 | Special port read data |
| br_req | output | 1 | Branch request from a write to index 15 |
| br_target | output | 32 | Branch target |
| br_fault | output | 1 | Write to index 15 with bit 0 clear |

## Verification
Some rules are checked by assertions on every cycle. These are the word step of push and pop on the active pointer, the win of a special write over stack traffic, the selection staying put across special writes, the zero low bits seen through index 13, the pipelined value read from index 15, and the exclusion of branch request and fault. Other behaviour can only be shown by the bench scenarios. That covers the old-value-on-collision read, storage of arbitrary patterns in the ordinary registers, the reset choice of the main pointer, and the separation of the two pointers across a change of selection. The bench also shows the simultaneous push and pop, with the exact stack address presented.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
   typedef enum logic {
      SP_MAIN = 1'b0,
      SP_PROC = 1'b1
   } sp_bank_e;

   localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/bsp_gpr_bank.sv
module bsp_gpr_bank #(
   parameter int unsigned DW     = 32,
   parameter int unsigned NREG   = 16,
   parameter int unsigned SP_IDX = 13,
   parameter int unsigned PC_IDX = 15,
   localparam int unsigned IW    = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] regs_q [NREG]
);
   // Ordinary storage; no reset, contents undefined until written.
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == SP_IDX || i == PC_IDX) begin : g_hole
         assign regs_q[i] = '0;
      end else begin : g_store
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IW'(i)) q <= wr_data;
         end
         assign regs_q[i] = q;
      end
   end
endmodule

// File: rtl/bsp_sp_bank.sv
module bsp_sp_bank
   import bsp_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter int unsigned STEP    = 4,
   parameter logic [31:0] RST_VAL = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_ld,
   input  logic          sel_val,
   input  logic          port_wr,
   input  logic [DW-1:0] port_data,
   input  logic          push,
   input  logic          pop,
   input  logic          spc_sel,
   input  logic          spc_wr,
   input  logic [DW-1:0] spc_wdata,
   output logic [DW-1:0] cur_sp,
   output logic [DW-1:0] spc_rdata,
   output logic [DW-1:0] stk_addr
);
   localparam logic [DW-1:0] ALIGN_MASK = ~DW'(STEP - 1);

   if (STEP < 2 || (STEP & (STEP - 1)) != 0) begin : g_chk_step
      $error("STEP must be a power of two of at least 2");
   end

   sp_bank_e      act_q;
   logic [DW-1:0] sp_q [NUM_BANKS];
   logic [DW-1:0] dec_v, inc_v, nxt_cur;

   assign cur_sp    = sp_q[act_q];
   assign spc_rdata = sp_q[spc_sel];
   assign dec_v     = cur_sp - DW'(STEP);
   assign inc_v     = cur_sp + DW'(STEP);
   assign stk_addr  = push ? dec_v : cur_sp;

   // Push beats pop; stack traffic beats the ordinary write port.
   always_comb begin
      if (push)         nxt_cur = dec_v;
      else if (pop)     nxt_cur = inc_v;
      else if (port_wr) nxt_cur = port_data & ALIGN_MASK;
      else              nxt_cur = cur_sp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q <= SP_MAIN;
      else if (sel_ld) act_q <= sp_bank_e'(sel_val);
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sp_q[b] <= RST_VAL[DW-1:0] & ALIGN_MASK;
         else if (spc_wr && spc_sel == 1'(b))
            sp_q[b] <= spc_wdata & ALIGN_MASK;
         else if (act_q == sp_bank_e'(b))
            sp_q[b] <= nxt_cur;
      end
   end

   // R5: push lowers the active pointer by one word
   a_r5_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !sel_ld && !(spc_wr && spc_sel == act_q)) |=> cur_sp == $past(cur_sp) - DW'(STEP));

   // R6: pop raises the active pointer by one word
   a_r6_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !sel_ld && !(spc_wr && spc_sel == act_q)) |=> cur_sp == $past(cur_sp) + DW'(STEP));

   // R7: special write lands in the named pointer regardless of stack traffic
   a_r7_spc_wins: assert property (@(posedge clk) disable iff (!rst_n)
      spc_wr |=> spc_rdata == ($past(spc_wdata) & ALIGN_MASK) || spc_sel != $past(spc_sel));

   // R7: special writes do not move the selection
   a_r7_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_wr && !sel_ld) |=> act_q == $past(act_q));
endmodule

// File: rtl/bsp_pc_port.sv
module bsp_pc_port #(
   parameter int unsigned DW     = 32,
   parameter int unsigned PC_OFS = 4
) (
   input  logic [DW-1:0] pc_cur,
   input  logic          pc_wr,
   input  logic [DW-1:0] pc_wdata,
   output logic [DW-1:0] pc_rd,
   output logic          br_req,
   output logic [DW-1:0] br_target,
   output logic          br_fault
);
   logic [DW-1:0] ahead;
   assign ahead     = pc_cur + DW'(PC_OFS);
   assign pc_rd     = {ahead[DW-1:1], 1'b0};
   assign br_target = pc_wdata;
   assign br_req    = pc_wr &  pc_wdata[0];
   assign br_fault  = pc_wr & ~pc_wdata[0];
endmodule

// File: rtl/bsp_regfile.sv
module bsp_regfile #(
   parameter int unsigned DW      = 32,
   parameter int unsigned NREG    = 16,
   parameter int unsigned SP_IDX  = 13,
   parameter int unsigned PC_IDX  = 15,
   parameter int unsigned STEP    = 4,
   parameter int unsigned PC_OFS  = 4,
   parameter logic [31:0] SP_RST  = 32'h0,
   localparam int unsigned IW     = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_ld,
   input  logic          sel_val,
   input  logic [IW-1:0] rd_a_idx,
   output logic [DW-1:0] rd_a_data,
   input  logic [IW-1:0] rd_b_idx,
   output logic [DW-1:0] rd_b_data,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] pc_cur,
   input  logic          push,
   input  logic          pop,
   output logic [DW-1:0] stk_addr,
   input  logic          spc_sel,
   input  logic          spc_wr,
   input  logic [DW-1:0] spc_wdata,
   output logic [DW-1:0] spc_rdata,
   output logic          br_req,
   output logic [DW-1:0] br_target,
   output logic          br_fault
);
   if (SP_IDX >= NREG || PC_IDX >= NREG || SP_IDX == PC_IDX) begin : g_chk_idx
      $error("SP_IDX and PC_IDX must be distinct indices below NREG");
   end
   if (DW < 8) begin : g_chk_dw
      $error("DW must be at least 8");
   end

   logic [DW-1:0] regs_q [NREG];
   logic [DW-1:0] cur_sp, pc_rd;
   logic          sp_wr, pc_wr;

   assign sp_wr = wr_en && wr_idx == IW'(SP_IDX);
   assign pc_wr = wr_en && wr_idx == IW'(PC_IDX);

   bsp_gpr_bank #(.DW(DW), .NREG(NREG), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_gpr (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .regs_q(regs_q)
   );

   bsp_sp_bank #(.DW(DW), .STEP(STEP), .RST_VAL(SP_RST)) u_sp (
      .clk(clk), .rst_n(rst_n), .sel_ld(sel_ld), .sel_val(sel_val),
      .port_wr(sp_wr), .port_data(wr_data), .push(push), .pop(pop),
      .spc_sel(spc_sel), .spc_wr(spc_wr), .spc_wdata(spc_wdata),
      .cur_sp(cur_sp), .spc_rdata(spc_rdata), .stk_addr(stk_addr)
   );

   bsp_pc_port #(.DW(DW), .PC_OFS(PC_OFS)) u_pc (
      .pc_cur(pc_cur), .pc_wr(pc_wr), .pc_wdata(wr_data), .pc_rd(pc_rd),
      .br_req(br_req), .br_target(br_target), .br_fault(br_fault)
   );

   function automatic logic [DW-1:0] pick(input logic [IW-1:0] idx);
      if (idx == IW'(SP_IDX))      return cur_sp;
      else if (idx == IW'(PC_IDX)) return pc_rd;
      else                         return regs_q[idx];
   endfunction

   assign rd_a_data = pick(rd_a_idx);
   assign rd_b_data = pick(rd_b_idx);

   // R3: stack pointer seen through the index is always word aligned
   a_r3_sp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      rd_b_idx == IW'(SP_IDX) |-> rd_b_data[1:0] == 2'b00);

   // R8: index 15 reads the pipelined address with bit 0 clear
   a_r8_pc_ahead: assert property (@(posedge clk) disable iff (!rst_n)
      rd_a_idx == IW'(PC_IDX) |-> (rd_a_data[0] == 1'b0 && rd_a_data[DW-1:1] == (pc_cur[DW-1:1] + (DW-1)'(PC_OFS / 2))));

   // R9: branch request and fault exclude each other
   a_r9_br_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({br_req, br_fault}));
endmodule

// File: tb/sim_bsp_regfile.sv
module sim_bsp_regfile;
   logic        clk = 0, rst_n = 0;
   logic        sel_ld = 0, sel_val = 0, wr_en = 0, push = 0, pop = 0;
   logic        spc_sel = 0, spc_wr = 0;
   logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
   logic [31:0] wr_data = 0, pc_cur = 0, spc_wdata = 0;
   logic [31:0] rd_a_data, rd_b_data, stk_addr, spc_rdata, br_target;
   logic        br_req, br_fault;
   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bsp_regfile u0 (.*);

   localparam int NV = 6;
   localparam logic [3:0]  V_IDX [NV] = '{4'd0, 4'd5, 4'd12, 4'd14, 4'd7, 4'd14};
   localparam logic [31:0] V_DAT [NV] = '{32'hDEAD_BEEF, 32'h0000_0001, 32'hFFFF_FFFF,
                                          32'h1234_5679, 32'hA5A5_5A5A, 32'h0000_0000};

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      wr_en = 0; push = 0; pop = 0; spc_wr = 0; sel_ld = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state: main pointer active and zero, no branch
      rd_a_idx = 13; #1;
      chk("R4 reset sp", rd_a_data, 32'h0);
      chk("R9 reset br", {30'b0, br_req, br_fault}, 32'h0);
      rst_n = 1;
      step();

      // R1/R2: table of writes and read-backs
      for (int i = 0; i < NV; i++) begin
         wr_en = 1; wr_idx = V_IDX[i]; wr_data = V_DAT[i];
         step(); idle();
         rd_a_idx = V_IDX[i]; rd_b_idx = V_IDX[i]; #1;
         chk(V_IDX[i] == 14 ? "R2 lr readback" : "R1 readback", rd_a_data, V_DAT[i]);
         chk("R11 port b", rd_b_data, V_DAT[i]);
      end

      // R1: same-cycle read returns old value
      wr_en = 1; wr_idx = 3; wr_data = 32'h1111_1111; step();
      wr_data = 32'h2222_2222; rd_a_idx = 3; #1;
      chk("R1 old on collision", rd_a_data, 32'h1111_1111);
      step(); idle(); #1;
      chk("R1 new next cycle", rd_a_data, 32'h2222_2222);

      // R11: independent ports
      rd_a_idx = 0; rd_b_idx = 12; #1;
      chk("R11 port a", rd_a_data, 32'hDEAD_BEEF);
      chk("R11 port b", rd_b_data, 32'hFFFF_FFFF);

      // R3: low bits forced on write port
      wr_en = 1; wr_idx = 13; wr_data = 32'h1000_0007; step(); idle();
      rd_a_idx = 13; #1;
      chk("R3 sp aligned", rd_a_data, 32'h1000_0004);

      // R5: push
      push = 1; #1;
      chk("R5 push addr", stk_addr, 32'h1000_0000);
      step(); idle(); #1;
      chk("R5 push sp", rd_a_data, 32'h1000_0000);

      // R6: pop
      pop = 1; #1;
      chk("R6 pop addr", stk_addr, 32'h1000_0000);
      step(); idle(); #1;
      chk("R6 pop sp", rd_a_data, 32'h1000_0004);

      // R7/R3: special write to the inactive pointer
      spc_sel = 1; spc_wr = 1; spc_wdata = 32'h2000_0103; step(); idle(); #1;
      chk("R3 spc aligned", spc_rdata, 32'h2000_0100);
      chk("R7 active kept", rd_a_data, 32'h1000_0004);

      // R4: switch to process pointer
      sel_ld = 1; sel_val = 1; step(); idle(); #1;
      chk("R4 process visible", rd_a_data, 32'h2000_0100);

      // R7: special write beats push on the same pointer
      push = 1; spc_sel = 1; spc_wr = 1; spc_wdata = 32'h3000_0000; #1;
      chk("R5 push addr proc", stk_addr, 32'h2000_00FC);
      step(); idle(); #1;
      chk("R7 spc wins", rd_a_data, 32'h3000_0000);

      // R10: push and pop together
      push = 1; pop = 1; #1;
      chk("R10 addr", stk_addr, 32'h2FFF_FFFC);
      step(); idle(); #1;
      chk("R10 sp", rd_a_data, 32'h2FFF_FFFC);

      // R4: back to main, pointers kept apart
      sel_ld = 1; sel_val = 0; step(); idle(); spc_sel = 1; #1;
      chk("R4 main again", rd_a_data, 32'h1000_0004);
      chk("R7 proc via spc", spc_rdata, 32'h2FFF_FFFC);
      spc_sel = 0; #1;
      chk("R7 main via spc", spc_rdata, 32'h1000_0004);

      // R8: pc read
      pc_cur = 32'h0000_1000; rd_a_idx = 15; #1;
      chk("R8 pc plus 4", rd_a_data, 32'h0000_1004);
      pc_cur = 32'h0000_1001; #1;
      chk("R8 pc bit0", rd_a_data, 32'h0000_1004);

      // R9: branch and fault
      wr_en = 1; wr_idx = 15; wr_data = 32'h0000_2001; #1;
      chk("R9 br_req", {31'b0, br_req}, 32'h1);
      chk("R9 target", br_target, 32'h0000_2001);
      chk("R9 no fault", {31'b0, br_fault}, 32'h0);
      wr_data = 32'h0000_2000; #1;
      chk("R9 fault", {31'b0, br_fault}, 32'h1);
      chk("R9 no req", {31'b0, br_req}, 32'h0);
      step(); idle(); #1;
      chk("R9 idle", {30'b0, br_req, br_fault}, 32'h0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule